// File: doc/BRIEF.md
# One-hot four-phase channel to request/grant bridge

The block joins a delay-insensitive, four-phase channel to a clocked request/grant port, in both directions. On the clockless side a word is a set of digits. Each digit carries two bits on four one-hot wires, and each channel has a single acknowledge wire for flow control. Between two words every wire returns to low (the neutral state).

On the receive side the block first synchronises each incoming wire. It then waits until every digit holds a legal code and latches the word into a one-entry holding register. It raises the acknowledge and keeps it high until the sender has brought every wire back to neutral. The latched word is offered on a request/grant port. It leaves on a clock edge where request and grant are both high.

On the transmit side a word is taken on a request/grant edge and driven as one-hot digits. The block removes those digits once the synchronised acknowledge goes high. It grants a new word only after that acknowledge has been seen low again.

Top module: `rail_bridge`

## Requirements
- R1: Digit i of a word occupies data bits [2i+1:2i] and wires [4i+3:4i]. A digit value k is sent by raising only wire 4i+k of that group.
- R2: A word whose digits all hold a single high wire is latched once. The clock edge that latches it also raises rx_req_o and rx_ack_o. That is the third rising edge after the wires settle, and the acknowledge is low before that edge.
- R3: While any digit is still neutral, the receive side raises neither the acknowledge nor the request.
- R4: After a word is latched, the acknowledge stays high while any wire is high. It falls on the third rising edge after all wires read neutral.
- R5: A received word moves out on a rising edge with rx_req_o and rx_gnt_i both high, and rx_req_o is low after that edge. While the grant is low, the request and the data hold.
- R6: A complete word that arrives while the holding register is full is not acknowledged. It is latched, and acknowledged, on the edge after the one that empties the register.
- R7: A digit with two or more high wires sets rx_err_o, which stays high until reset. Such a word is not acknowledged, and later legal words are still received.
- R8: tx_gnt_o is high only when the transmit side is idle and the synchronised acknowledge is low. It falls two edges after tx_ack_i rises, and no wire is driven while it is low.
- R9: On a rising edge with tx_req_i and tx_gnt_o high, tx_data_i is encoded per R1 onto tx_rails_o, which is valid after that edge. The grant is then low.
- R10: The driven wires return to neutral on the third rising edge after tx_ack_i rises. The grant returns on the third rising edge after tx_ack_i falls.
- R11: After reset, the receive acknowledge, receive request and error flag are low and the transmit wires are neutral. With tx_ack_i low, the grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the synchronous side |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| rx_rails_i | input | 4*DIGITS | One-hot digit wires from the clockless sender |
| rx_ack_o | output | 1 | Acknowledge back to the clockless sender |
| rx_req_o | output | 1 | A received word is waiting |
| rx_gnt_i | input | 1 | Consumer takes the waiting word on this edge |
| rx_data_o | output | 2*DIGITS | Decoded received word |
| rx_err_o | output | 1 | Sticky flag for an illegal digit code |
| tx_req_i | input | 1 | Producer offers a word |
| tx_gnt_o | output | 1 | Transmit side accepts a word on this edge |
| tx_data_i | input | 2*DIGITS | Word to send |
| tx_rails_o | output | 4*DIGITS | One-hot digit wires to the clockless receiver |
| tx_ack_i | input | 1 | Acknowledge from the clockless receiver |

## Verification
Every possible word of a two-digit configuration passes through both directions. This confirms that each digit value selects its own wire and decodes back to the same bits, and a swapped wire or digit would show up on at least one value. Words built up one digit at a time show whether completion waits for the slowest digit. Multi-hot digits show whether a bad code is held back and flagged. A second word sent while the first is still waiting separates correct back pressure from overwriting. Acknowledge edges raised while the transmitter is idle or driving show whether the grant and the return to neutral follow the synchronised acknowledge with the expected latency.

// File: rtl/rail_pkg.sv
package rail_pkg;

  typedef enum logic {RX_WAIT, RX_RTZ} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_RTZ} tx_state_t;

  // exactly one wire of the group high
  function automatic logic digit_valid(input logic [3:0] w);
    return $countones(w) == 1;
  endfunction

  // two or more wires of the group high
  function automatic logic digit_multi(input logic [3:0] w);
    return $countones(w) > 1;
  endfunction

  // wire index of a single-hot group
  function automatic logic [1:0] digit_value(input logic [3:0] w);
    return {w[3] | w[2], w[3] | w[1]};
  endfunction

  function automatic logic [3:0] digit_encode(input logic [1:0] v);
    return 4'b0001 << v;
  endfunction

endpackage

// File: rtl/rail_sync2.sv
module rail_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rail_rx_path.sv
module rail_rx_path
  import rail_pkg::*;
#(
  parameter int DIGITS = 18,
  localparam int RW = 4 * DIGITS,
  localparam int DW = 2 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rails_s_i,
  input  logic          gnt_i,
  output logic          ack_o,
  output logic          req_o,
  output logic [DW-1:0] data_o,
  output logic          err_o
);
  logic [DIGITS-1:0] dig_ok, dig_bad;
  logic [DW-1:0]     dec_word;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dig_ok[i]          = digit_valid(rails_s_i[4*i +: 4]);
    assign dig_bad[i]         = digit_multi(rails_s_i[4*i +: 4]);
    assign dec_word[2*i +: 2] = digit_value(rails_s_i[4*i +: 4]);
  end

  logic all_ok, any_bad, all_neutral;
  assign all_ok      = &dig_ok;
  assign any_bad     = |dig_bad;
  assign all_neutral = (rails_s_i == '0);

  rx_state_t     st_q, st_d;
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;
  logic          err_q, err_d;
  logic          load;

  always_comb begin
    st_d   = st_q;
    full_d = full_q;
    data_d = data_q;
    err_d  = err_q | any_bad;
    load   = (st_q == RX_WAIT) && !full_q && all_ok;
    if (full_q && gnt_i) full_d = 1'b0;
    unique case (st_q)
      RX_WAIT: if (load) begin
        st_d   = RX_RTZ;
        full_d = 1'b1;
        data_d = dec_word;
      end
      RX_RTZ: if (all_neutral) st_d = RX_WAIT;
      default: st_d = RX_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_WAIT;
      full_q <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      full_q <= full_d;
      err_q  <= err_d;
      if (load) data_q <= data_d;
    end
  end

  assign ack_o  = (st_q == RX_RTZ);
  assign req_o  = full_q;
  assign data_o = data_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rail_tx_path.sv
module rail_tx_path
  import rail_pkg::*;
#(
  parameter int DIGITS = 18,
  localparam int RW = 4 * DIGITS,
  localparam int DW = 2 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_s_i,
  output logic          gnt_o,
  output logic [RW-1:0] rails_o
);
  logic [RW-1:0] enc_word;

  for (genvar i = 0; i < DIGITS; i++) begin : g_enc
    assign enc_word[4*i +: 4] = digit_encode(data_i[2*i +: 2]);
  end

  tx_state_t     st_q, st_d;
  logic [RW-1:0] rails_q, rails_d;
  logic          rails_en;

  assign gnt_o = (st_q == TX_IDLE) && !ack_s_i;

  always_comb begin
    st_d     = st_q;
    rails_d  = rails_q;
    rails_en = 1'b0;
    unique case (st_q)
      TX_IDLE: if (req_i && gnt_o) begin
        st_d     = TX_DRIVE;
        rails_d  = enc_word;
        rails_en = 1'b1;
      end
      TX_DRIVE: if (ack_s_i) begin
        st_d     = TX_RTZ;
        rails_d  = '0;
        rails_en = 1'b1;
      end
      TX_RTZ: if (!ack_s_i) st_d = TX_IDLE;
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      rails_q <= '0;
    end else begin
      st_q <= st_d;
      if (rails_en) rails_q <= rails_d;
    end
  end

  assign rails_o = rails_q;
endmodule

// File: rtl/rail_bridge.sv
module rail_bridge #(
  parameter int DIGITS = 18,
  localparam int RW = 4 * DIGITS,
  localparam int DW = 2 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rx_rails_i,
  output logic          rx_ack_o,
  output logic          rx_req_o,
  input  logic          rx_gnt_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_err_o,
  input  logic          tx_req_i,
  output logic          tx_gnt_o,
  input  logic [DW-1:0] tx_data_i,
  output logic [RW-1:0] tx_rails_o,
  input  logic          tx_ack_i
);
  logic [RW-1:0] rx_rails_s;
  logic          tx_ack_s;

  rail_sync2 #(.W(RW)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_rails_i), .q_o(rx_rails_s)
  );

  rail_sync2 #(.W(1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tx_ack_i), .q_o(tx_ack_s)
  );

  rail_rx_path #(.DIGITS(DIGITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rails_s_i(rx_rails_s), .gnt_i(rx_gnt_i),
    .ack_o(rx_ack_o), .req_o(rx_req_o), .data_o(rx_data_o), .err_o(rx_err_o)
  );

  rail_tx_path #(.DIGITS(DIGITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .req_i(tx_req_i), .data_i(tx_data_i),
    .ack_s_i(tx_ack_s), .gnt_o(tx_gnt_o), .rails_o(tx_rails_o)
  );
endmodule

// File: rtl/rail_bridge_chk.sv
module rail_bridge_chk #(
  parameter int DIGITS = 18,
  localparam int RW = 4 * DIGITS,
  localparam int DW = 2 * DIGITS
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] rx_rails_i,
  input logic          rx_ack_o,
  input logic          rx_req_o,
  input logic          rx_gnt_i,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_err_o,
  input logic          tx_req_i,
  input logic          tx_gnt_o,
  input logic [DW-1:0] tx_data_i,
  input logic [RW-1:0] tx_rails_o,
  input logic          tx_ack_i
);
  logic tx_multi;

  always_comb begin
    tx_multi = 1'b0;
    for (int i = 0; i < DIGITS; i++)
      if ($countones(tx_rails_o[4*i +: 4]) > 1) tx_multi = 1'b1;
  end

  // R1
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_multi);

  // R2
  ack_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack_o) |-> $rose(rx_req_o));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_o && !rx_gnt_i |=> rx_req_o && $stable(rx_data_o));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_o && rx_gnt_i |=> !rx_req_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> rx_err_o);

  // R8
  gnt_neutral_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt_o |-> tx_rails_o == '0);

  // R9
  tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_i && tx_gnt_o |=> tx_rails_o != '0 && !tx_gnt_o);
endmodule

bind rail_bridge rail_bridge_chk #(.DIGITS(DIGITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_rails_i(rx_rails_i), .rx_ack_o(rx_ack_o),
  .rx_req_o(rx_req_o), .rx_gnt_i(rx_gnt_i), .rx_data_o(rx_data_o),
  .rx_err_o(rx_err_o), .tx_req_i(tx_req_i), .tx_gnt_o(tx_gnt_o),
  .tx_data_i(tx_data_i), .tx_rails_o(tx_rails_o), .tx_ack_i(tx_ack_i)
);

// File: tb/rail_bridge_tb.sv
`timescale 1ns/1ps
module rail_bridge_tb_top;
  localparam int D  = 2;
  localparam int RW = 4 * D;
  localparam int DW = 2 * D;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] rx_rails;
  logic          rx_ack, rx_req, rx_gnt, rx_err;
  logic [DW-1:0] rx_data;
  logic          tx_req, tx_gnt, tx_ack;
  logic [DW-1:0] tx_data;
  logic [RW-1:0] tx_rails;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rail_bridge #(.DIGITS(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_rails_i(rx_rails), .rx_ack_o(rx_ack),
    .rx_req_o(rx_req), .rx_gnt_i(rx_gnt), .rx_data_o(rx_data), .rx_err_o(rx_err),
    .tx_req_i(tx_req), .tx_gnt_o(tx_gnt), .tx_data_i(tx_data),
    .tx_rails_o(tx_rails), .tx_ack_i(tx_ack)
  );

  // one-hot image of a word, computed digit by digit
  function automatic logic [RW-1:0] expect_rails(input int v);
    logic [RW-1:0] r = '0;
    for (int i = 0; i < D; i++) r[4*i + ((v >> (2*i)) & 3)] = 1'b1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rx_word(input int v);
    rx_rails = expect_rails(v);
    step(2);
    check(rx_ack == 1'b0, "R2 early ack", rx_ack, 0);
    step(1);
    check(rx_ack == 1'b1 && rx_req == 1'b1, "R2 ack/req", {rx_ack, rx_req}, 3);
    check(rx_data == DW'(v), "R1 R2 data", rx_data, v);
    step(2);
    check(rx_req == 1'b1 && rx_data == DW'(v), "R5 hold", rx_data, v);
    rx_gnt = 1'b1;
    step(1);
    rx_gnt = 1'b0;
    check(rx_req == 1'b0, "R5 taken", rx_req, 0);
    check(rx_ack == 1'b1, "R4 ack held", rx_ack, 1);
    rx_rails = '0;
    step(2);
    check(rx_ack == 1'b1, "R4 ack before neutral seen", rx_ack, 1);
    step(1);
    check(rx_ack == 1'b0, "R4 ack drop", rx_ack, 0);
  endtask

  task automatic tx_word(input int v);
    tx_req  = 1'b1;
    tx_data = DW'(v);
    check(tx_gnt == 1'b1, "R8 idle grant", tx_gnt, 1);
    step(1);
    tx_req = 1'b0;
    check(tx_rails == expect_rails(v), "R1 R9 rails", tx_rails, expect_rails(v));
    check(tx_gnt == 1'b0, "R9 grant low", tx_gnt, 0);
    tx_ack = 1'b1;
    step(2);
    check(tx_rails == expect_rails(v), "R10 rails held", tx_rails, expect_rails(v));
    step(1);
    check(tx_rails == '0, "R10 rails neutral", tx_rails, 0);
    tx_ack = 1'b0;
    step(2);
    check(tx_gnt == 1'b0, "R10 grant early", tx_gnt, 0);
    step(1);
    check(tx_gnt == 1'b1, "R10 grant back", tx_gnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_rails = '0; rx_gnt = 1'b0;
    tx_req = 1'b0; tx_data = '0; tx_ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11
    check(!rx_ack && !rx_req && !rx_err, "R11 rx reset", {rx_ack, rx_req, rx_err}, 0);
    check(tx_rails == '0 && tx_gnt, "R11 tx reset", {tx_gnt, tx_rails}, 9'h100);

    for (int v = 0; v < (1 << DW); v++) rx_word(v);

    // R3: one digit arrives first
    rx_rails = 8'h02;
    step(4);
    check(!rx_ack && !rx_req, "R3 partial word", {rx_ack, rx_req}, 0);
    rx_rails = 8'h42;
    step(2);
    check(!rx_ack, "R3 completion early", rx_ack, 0);
    step(1);
    check(rx_ack && rx_data == 4'h9, "R3 completed word", rx_data, 9);
    rx_gnt = 1'b1; step(1); rx_gnt = 1'b0;
    rx_rails = '0; step(3);

    // R6: back pressure
    rx_rails = expect_rails(5); step(3);
    rx_rails = '0; step(3);
    check(!rx_ack && rx_req, "R6 first waiting", {rx_ack, rx_req}, 1);
    rx_rails = expect_rails(10); step(4);
    check(!rx_ack && rx_req && rx_data == 4'h5, "R6 second blocked", rx_data, 5);
    rx_gnt = 1'b1; step(1); rx_gnt = 1'b0;
    check(!rx_ack && !rx_req, "R6 register emptied", {rx_ack, rx_req}, 0);
    step(1);
    check(rx_ack && rx_req && rx_data == 4'hA, "R6 second latched", rx_data, 10);
    rx_gnt = 1'b1; step(1); rx_gnt = 1'b0;
    rx_rails = '0; step(3);

    // R7: illegal code
    check(!rx_err, "R7 no error yet", rx_err, 0);
    rx_rails = 8'h13; step(3);
    check(rx_err && !rx_ack && !rx_req, "R7 illegal flagged", {rx_err, rx_ack, rx_req}, 4);
    step(3);
    check(!rx_ack, "R7 illegal not taken", rx_ack, 0);
    rx_rails = '0; step(3);
    rx_word(6);
    check(rx_err, "R7 error sticky", rx_err, 1);

    for (int v = 0; v < (1 << DW); v++) tx_word(v);

    // R8: acknowledge high while idle blocks the grant
    tx_ack = 1'b1; step(1);
    check(tx_gnt, "R8 grant before sync", tx_gnt, 1);
    step(1);
    check(!tx_gnt, "R8 grant withdrawn", tx_gnt, 0);
    tx_req = 1'b1; tx_data = 4'h3; step(3);
    check(tx_rails == '0 && !tx_gnt, "R8 no drive", tx_rails, 0);
    tx_req = 1'b0; tx_ack = 1'b0; step(3);
    check(tx_gnt, "R8 grant restored", tx_gnt, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule